// File: doc/BRIEF.md
# Interrupt Vector and Trap Control Unit

This unit holds two byte-wide registers on the processor's internal I/O register bus. The vector base register supplies the upper three bits of every interrupt vector built for the external request pins and the on-chip sources. The trap control register holds the three interrupt-level enables, a sticky trap flag and a read-only flag that records which opcode byte was undefined.

The instruction decoder pulses `undef_op` when it fetches an undefined opcode. With that pulse it gives `undef_third`, which tells whether the faulting opcode begins two bytes or one byte below the stacked program counter. The unit then raises a one-cycle non-maskable trap request, sets the trap flag and captures the byte-position flag, so the handler can adjust the stacked PC.

The unit also gates the raw level requests with their enables for the arbiter downstream. It builds the low vector byte from the base bits and a four-bit code for the on-chip source. Priority arbitration and stacking happen elsewhere.

Top module: `itc_top`

## Requirements
- R1: After reset the vector base bits are 0, the level enables are 3'b001 (level 0 on, levels 1 and 2 off), the trap flag is 0 and the byte-position flag is 0.
- R2: A write to address 0x33 stores data bits 7:5 as the vector base. A read from 0x33 returns the base in bits 7:5 and 0 in bits 4:0.
- R3: A write to address 0x34 stores data bits 2:0 as the enables for levels 2, 1 and 0. A read from 0x34 returns {trap, ufo, 3'b000, enables}. Bits 5:3 always read 0, and written values there are dropped.
- R4: Writing 0 to bit 7 at 0x34 clears the trap flag. Writing 1 there leaves the flag unchanged and never sets it.
- R5: An `undef_op` pulse sets the trap flag at the next clock edge. It wins over a clearing write in the same cycle.
- R6: Bit 6 at 0x34 is read-only. It is loaded from `undef_third` on the edge that sets the trap flag, and it keeps its value until the next `undef_op`. Software writes do not change it.
- R7: `trap_req` is high for exactly the one cycle after each `undef_op` cycle, whatever the level enables are.
- R8: `vec_byte` equals {base[2:0], src_id[3:0], 1'b0} at all times.
- R9: `lvl_req_out[i]` is `lvl_req_in[i]` when enable i is 1, and 0 when enable i is 0.
- R10: Reads from any address other than 0x33 and 0x34 return 0, and writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | I/O register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| undef_op | input | 1 | Undefined-opcode pulse from the decoder |
| undef_third | input | 1 | 1: faulting opcode at stacked PC-2, 0: at PC-1 |
| lvl_req_in | input | 3 | Raw requests for levels 2..0 |
| src_id | input | 4 | Code of the interrupt source being vectored |
| trap_req | output | 1 | Non-maskable trap request pulse |
| lvl_en | output | 3 | Level enables 2..0 |
| lvl_req_out | output | 3 | Requests gated by their enables |
| vec_byte | output | 8 | Low byte of the interrupt vector |

## Verification
A reference model in the bench is compared with the outputs on every cycle. Directed phases come first. Write-1 and write-0 to the trap bit tell the one-way clear apart from a plain read/write bit. A trap together with a clearing write in the same cycle shows which of the two wins. Traps with alternating `undef_third` values, followed by software writes to bit 6, show that the flag is captured and then held. A long random phase then mixes addresses inside and outside the map with trap pulses, source codes and request patterns under every enable setting. This exposes decoding slips and masking faults.

// File: rtl/itc_pkg.sv
package itc_pkg;
   localparam int DATA_W = 8;
   localparam int LVL_N  = 3;

   typedef struct packed {
      logic             trap;
      logic             ufo;
      logic [LVL_N-1:0] en;
   } ctl_view_t;
endpackage

// File: rtl/itc_ctl_regs.sv
module itc_ctl_regs
   import itc_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h33,
   parameter logic [ADDR_W-1:0] CTL_ADDR  = 8'h34,
   parameter int BASE_W   = 3,
   parameter logic [LVL_N-1:0] EN_RST = 3'b001
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                wr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                trap_flag,
   input  logic                ufo_flag,
   output logic [BASE_W-1:0]   base_bits,
   output logic [LVL_N-1:0]    lvl_en,
   output logic                trap_clr,
   output logic [DATA_W-1:0]   rdata
);
   localparam int BASE_LSB = DATA_W - BASE_W;

   logic      hit_base, hit_ctl;
   ctl_view_t view;

   assign hit_base = (addr == BASE_ADDR);
   assign hit_ctl  = (addr == CTL_ADDR);
   assign trap_clr = wr & hit_ctl & ~wdata[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_bits <= '0;
         lvl_en    <= EN_RST;
      end else if (wr) begin
         if (hit_base) base_bits <= wdata[DATA_W-1:BASE_LSB];
         if (hit_ctl)  lvl_en    <= wdata[LVL_N-1:0];
      end
   end

   always_comb begin
      view.trap = trap_flag;
      view.ufo  = ufo_flag;
      view.en   = lvl_en;
      rdata     = '0;
      if (hit_base)
         rdata[DATA_W-1:BASE_LSB] = base_bits;
      else if (hit_ctl) begin
         rdata[DATA_W-1]  = view.trap;
         rdata[DATA_W-2]  = view.ufo;
         rdata[LVL_N-1:0] = view.en;
      end
   end

   // R3: an enable write lands on the following edge
   a_r3_en_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_ctl) |=> (lvl_en == $past(wdata[LVL_N-1:0])));
   // R10: outside the map nothing moves
   a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr && (hit_base || hit_ctl))) |=> ($stable(lvl_en) && $stable(base_bits)));
endmodule

// File: rtl/itc_trap_unit.sv
module itc_trap_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic undef_op,
   input  logic undef_third,
   input  logic trap_clr,
   output logic trap_flag,
   output logic ufo_flag,
   output logic trap_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_flag <= 1'b0;
         ufo_flag  <= 1'b0;
         trap_req  <= 1'b0;
      end else begin
         trap_req <= undef_op;
         if (undef_op) begin
            trap_flag <= 1'b1;
            ufo_flag  <= undef_third;
         end else if (trap_clr) begin
            trap_flag <= 1'b0;
         end
      end
   end

   a_r5_trap_sets: assert property (@(posedge clk) disable iff (!rst_n)
      undef_op |=> trap_flag);
   a_r4_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!undef_op && !trap_flag) |=> !trap_flag);
   a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
      undef_op |=> (ufo_flag == $past(undef_third)));
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !undef_op |=> $stable(ufo_flag));
   a_r7_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      undef_op |=> trap_req);
   a_r7_req_only_after: assert property (@(posedge clk) disable iff (!rst_n)
      !undef_op |=> !trap_req);
endmodule

// File: rtl/itc_vec_mask.sv
module itc_vec_mask
   import itc_pkg::*;
#(
   parameter int BASE_W = 3,
   parameter int SRC_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BASE_W-1:0] base_bits,
   input  logic [SRC_W-1:0]  src_id,
   input  logic [LVL_N-1:0]  lvl_en,
   input  logic [LVL_N-1:0]  lvl_req_in,
   output logic [LVL_N-1:0]  lvl_req_out,
   output logic [DATA_W-1:0] vec_byte
);
   assign vec_byte = {base_bits, src_id, 1'b0};

   for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
      assign lvl_req_out[g] = lvl_en[g] ? lvl_req_in[g] : 1'b0;
   end

   // R9: no request escapes a disabled level
   a_r9_masked_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((lvl_req_out & ~lvl_en) == '0));
endmodule

// File: rtl/itc_top.sv
module itc_top
   import itc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h33,
   parameter logic [ADDR_W-1:0] CTL_ADDR  = 8'h34,
   parameter int SRC_W  = 4,
   parameter logic [LVL_N-1:0] EN_RST = 3'b001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              undef_op,
   input  logic              undef_third,
   input  logic [2:0]        lvl_req_in,
   input  logic [SRC_W-1:0]  src_id,
   output logic              trap_req,
   output logic [2:0]        lvl_en,
   output logic [2:0]        lvl_req_out,
   output logic [7:0]        vec_byte
);
   localparam int BASE_W = DATA_W - SRC_W - 1;

   if (BASE_W < 1) begin : g_bad_src
      $error("SRC_W leaves no room for vector base bits");
   end
   if (BASE_ADDR == CTL_ADDR) begin : g_bad_map
      $error("register addresses collide");
   end
   if (BASE_W + 2 + LVL_N > DATA_W + BASE_W - 1 && BASE_W > DATA_W - LVL_N - 2) begin : g_bad_layout
      $error("base field overlaps enable field");
   end

   logic [BASE_W-1:0] base_bits;
   logic              trap_flag, ufo_flag, trap_clr;

   itc_ctl_regs #(
      .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .CTL_ADDR(CTL_ADDR),
      .BASE_W(BASE_W), .EN_RST(EN_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
      .trap_flag(trap_flag), .ufo_flag(ufo_flag), .base_bits(base_bits),
      .lvl_en(lvl_en), .trap_clr(trap_clr), .rdata(reg_rdata)
   );

   itc_trap_unit u_trap (
      .clk(clk), .rst_n(rst_n), .undef_op(undef_op), .undef_third(undef_third),
      .trap_clr(trap_clr), .trap_flag(trap_flag), .ufo_flag(ufo_flag),
      .trap_req(trap_req)
   );

   itc_vec_mask #(.BASE_W(BASE_W), .SRC_W(SRC_W)) u_vec (
      .clk(clk), .rst_n(rst_n), .base_bits(base_bits), .src_id(src_id),
      .lvl_en(lvl_en), .lvl_req_in(lvl_req_in), .lvl_req_out(lvl_req_out),
      .vec_byte(vec_byte)
   );
endmodule

// File: tb/tb_itc_top.sv
module tb_itc_top;
   localparam int PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] reg_addr = '0, reg_wdata = '0;
   logic       reg_wr = 1'b0, undef_op = 1'b0, undef_third = 1'b0;
   logic [2:0] lvl_req_in = '0;
   logic [3:0] src_id = '0;
   logic [7:0] reg_rdata, vec_byte;
   logic       trap_req;
   logic [2:0] lvl_en, lvl_req_out;

   int total = 0, bad = 0;
   bit done = 0;

   // reference model state
   logic [2:0] m_base;
   logic [2:0] m_en;
   logic       m_trap, m_ufo, m_treq;

   always #(PERIOD/2) clk = ~clk;

   itc_top dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .undef_op(undef_op),
      .undef_third(undef_third), .lvl_req_in(lvl_req_in), .src_id(src_id),
      .trap_req(trap_req), .lvl_en(lvl_en), .lvl_req_out(lvl_req_out),
      .vec_byte(vec_byte)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      logic [7:0] exp_rd;
      string      tag;
      if (reg_addr == 8'h33) begin
         exp_rd = {m_base, 5'b0}; tag = "R2 base read";
      end else if (reg_addr == 8'h34) begin
         exp_rd = {m_trap, m_ufo, 3'b000, m_en}; tag = "R3/R4/R5/R6 ctl read";
      end else begin
         exp_rd = 8'h00; tag = "R10 unmapped read";
      end
      chk(tag, reg_rdata, exp_rd);
      chk("R7 trap_req", {7'b0, trap_req}, {7'b0, m_treq});
      chk("R3 lvl_en", {5'b0, lvl_en}, {5'b0, m_en});
      chk("R9 lvl_req_out", {5'b0, lvl_req_out}, {5'b0, lvl_req_in & m_en});
      chk("R8 vec_byte", vec_byte, {m_base, src_id, 1'b0});
   endtask

   // one cycle: drive inputs now (after negedge), advance model at posedge, compare at next negedge
   task automatic step(input logic [7:0] a, input logic w, input logic [7:0] d,
                       input logic u, input logic t, input logic [2:0] rq, input logic [3:0] s);
      reg_addr = a; reg_wr = w; reg_wdata = d; undef_op = u; undef_third = t;
      lvl_req_in = rq; src_id = s;
      #1 compare_all();
      @(posedge clk);
      m_treq = u;
      if (w && a == 8'h33) m_base = d[7:5];
      if (w && a == 8'h34) begin
         m_en = d[2:0];
         if (!d[7]) m_trap = 1'b0;
      end
      if (u) begin
         m_trap = 1'b1;
         m_ufo  = t;
      end
      @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] a);
      step(a, 1'b0, 8'h00, 1'b0, 1'b0, 3'b111, 4'h5);
   endtask

   initial begin
      m_base = '0; m_en = 3'b001; m_trap = 0; m_ufo = 0; m_treq = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      reg_addr = 8'h34; #1;
      chk("R1 ctl after reset", reg_rdata, 8'h01);
      reg_addr = 8'h33; #1;
      chk("R1 base after reset", reg_rdata, 8'h00);
      chk("R1 trap_req after reset", {7'b0, trap_req}, 8'h00);

      // R2 base write with junk in low bits
      step(8'h33, 1, 8'hBF, 0, 0, 3'b000, 4'h0);
      rd(8'h33);
      // R3 enables, bits 5:3 dropped
      step(8'h34, 1, 8'h3E, 0, 0, 3'b111, 4'h0);
      rd(8'h34);
      // R4 write 1 to trap bit does not set it
      step(8'h34, 1, 8'h87, 0, 0, 3'b101, 4'h1);
      rd(8'h34);
      // R5/R6/R7 trap with PC-2 flag
      step(8'h00, 0, 8'h00, 1, 1, 3'b000, 4'h2);
      rd(8'h34);
      // R6 software write to bit 6 ignored, R4 write 1 keeps trap
      step(8'h34, 1, 8'hC7, 0, 0, 3'b010, 4'h3);
      rd(8'h34);
      // R4 clear by writing 0
      step(8'h34, 1, 8'h47, 0, 0, 3'b011, 4'h4);
      rd(8'h34);
      // R5 set wins over same-cycle clear, R6 now PC-1
      step(8'h34, 1, 8'h02, 1, 0, 3'b111, 4'h9);
      rd(8'h34);
      // R7 trap with all levels disabled
      step(8'h34, 1, 8'h00, 0, 0, 3'b111, 4'hA);
      step(8'h12, 0, 8'h00, 1, 1, 3'b111, 4'hF);
      rd(8'h34);
      // R10 writes outside map
      step(8'h35, 1, 8'hFF, 0, 0, 3'b111, 4'h6);
      step(8'h32, 1, 8'hFF, 0, 0, 3'b111, 4'h6);
      rd(8'h33); rd(8'h34); rd(8'hAA);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] a;
         int sel = $urandom_range(0, 3);
         a = (sel == 0) ? 8'h33 : (sel == 1) ? 8'h34 : 8'($urandom);
         step(a, 1'($urandom_range(0, 2) == 0), 8'($urandom),
              1'($urandom_range(0, 5) == 0), 1'($urandom),
              3'($urandom), 4'($urandom));
      end
      rd(8'h34);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule